// File: doc/BRIEF.md
# Branch Execution Sequencer

This block runs the execute phase of a relative branch in a three-stage fetch/decode/execute pipeline. A branch can optionally save a return address. When a start pulse arrives and the block is idle, it captures the current program counter, the 24-bit word offset and the link request. It then steps through three fixed cycles.

In the first cycle it forms the branch target and starts fetching from it. In the second cycle it advances the fetch address and, for a linking branch, writes the captured program counter to the link register. In the third cycle it advances the fetch address again and writes a corrected link value. Because of prefetch, the program counter seen in execute is two words past the branch itself. The correction subtracts one word, so the saved link points at the instruction that follows the branch.

While the sequence runs, the block holds the pipeline flushed so the stale prefetched words are dropped. It raises done in the last cycle. Decode, condition evaluation and memory stay outside the block.

Top module: `branch_seq`

## Requirements
- R1: After reset, busy_o, flush_o, fetch_o, lr_we_o and done_o are low and addr_o is zero.
- R2: A start_i seen high at a clock edge while idle makes addr_o equal pc_i + (offset_i sign-extended from bit 23, times 4), modulo 2^32, in the next cycle, with busy_o, flush_o and fetch_o high.
- R3: In the second busy cycle addr_o is one word (4) above its first-cycle value. For a linking branch, lr_we_o is high and lr_data_o equals the pc_i captured at start.
- R4: In the third busy cycle addr_o is one more word (4) higher. For a linking branch, lr_we_o is high and lr_data_o equals the captured pc_i minus 4.
- R5: busy_o and flush_o stay high for exactly three cycles. done_o is high only in the third of them and drops together with busy_o.
- R6: A branch started with link_i low keeps lr_we_o low throughout and still takes three cycles.
- R7: While busy, start_i is ignored, and changes on pc_i, offset_i or link_i have no effect on the running sequence.
- R8: When idle, fetch_o and lr_we_o are low and addr_o keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a branch (accepted only when idle) |
| link_i | input | 1 | Save a return address |
| offset_i | input | 24 | Signed word offset of the branch |
| pc_i | input | 32 | Program counter as seen in execute |
| addr_o | output | 32 | Address register value driven to memory |
| fetch_o | output | 1 | Fetch request from addr_o |
| lr_we_o | output | 1 | Link register write enable |
| lr_data_o | output | 32 | Link register write data |
| busy_o | output | 1 | Sequence in progress |
| flush_o | output | 1 | Discard prefetched pipeline contents |
| done_o | output | 1 | Final cycle of the sequence |

## Verification
The assertions assume that link writes only come in consecutive pairs from one branch. They also assume that a branch starts only from idle, so the word step between busy cycles is always well defined. Inputs may change at any time; the block samples them only at acceptance. The stimulus mixes random and directed offsets and PCs, including the most negative and most positive offsets and wrap-around across zero. It also drives a spurious start_i and random pc_i, offset_i and link_i while busy, and holds start_i low on the edge that returns the block to idle, so every sequence is checked from a clean start.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TGT  = 2'd1,
        ST_SAVE = 2'd2,
        ST_FIX  = 2'd3
    } bseq_state_e;

endpackage

// File: rtl/bseq_target_calc.sv
module bseq_target_calc #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 24,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [XLEN-1:0]  tgt_o
);
    localparam int PAD = XLEN - OFF_W - SHIFT;

    logic [XLEN-1:0] disp;

    generate
        if (SHIFT > 0) begin : g_shift
            assign disp = {{PAD{off_i[OFF_W-1]}}, off_i, {SHIFT{1'b0}}};
        end else begin : g_noshift
            assign disp = {{PAD{off_i[OFF_W-1]}}, off_i};
        end
    endgenerate

    assign tgt_o = base_i + disp;
endmodule

// File: rtl/bseq_step.sv
module bseq_step #(
    parameter int XLEN = 32,
    parameter int STEP = 4,
    parameter bit DOWN = 1'b0
) (
    input  logic [XLEN-1:0] val_i,
    output logic [XLEN-1:0] val_o
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    generate
        if (DOWN) begin : g_dec
            assign val_o = val_i - STEP_V;
        end else begin : g_inc
            assign val_o = val_i + STEP_V;
        end
    endgenerate
endmodule

// File: rtl/branch_seq.sv
module branch_seq
    import branch_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 24,
    parameter int SHIFT = 2,
    parameter int WORD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             link_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [XLEN-1:0]  pc_i,
    output logic [XLEN-1:0]  addr_o,
    output logic             fetch_o,
    output logic             lr_we_o,
    output logic [XLEN-1:0]  lr_data_o,
    output logic             busy_o,
    output logic             flush_o,
    output logic             done_o
);
    localparam logic [XLEN-1:0] WORD_V = XLEN'(WORD);

    typedef struct packed {
        bseq_state_e     state;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] lr;
        logic            link;
        logic            lr_we;
        logic            done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [XLEN-1:0] target_w;
    logic [XLEN-1:0] addr_next_w;
    logic [XLEN-1:0] lr_fixed_w;

    bseq_target_calc #(
        .XLEN (XLEN),
        .OFF_W(OFF_W),
        .SHIFT(SHIFT)
    ) u_tgt (
        .base_i(pc_i),
        .off_i (offset_i),
        .tgt_o (target_w)
    );

    bseq_step #(
        .XLEN(XLEN),
        .STEP(WORD),
        .DOWN(1'b0)
    ) u_addr_inc (
        .val_i(r_q.addr),
        .val_o(addr_next_w)
    );

    bseq_step #(
        .XLEN(XLEN),
        .STEP(WORD),
        .DOWN(1'b1)
    ) u_lr_fix (
        .val_i(r_q.lr),
        .val_o(lr_fixed_w)
    );

    always_comb begin
        r_d       = r_q;
        r_d.lr_we = 1'b0;
        r_d.done  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_TGT;
                    r_d.addr  = target_w;
                    r_d.pc    = pc_i;
                    r_d.link  = link_i;
                end
            end
            ST_TGT: begin
                r_d.state = ST_SAVE;
                r_d.addr  = addr_next_w;
                if (r_q.link) begin
                    r_d.lr_we = 1'b1;
                    r_d.lr    = r_q.pc;
                end
            end
            ST_SAVE: begin
                r_d.state = ST_FIX;
                r_d.addr  = addr_next_w;
                r_d.done  = 1'b1;
                if (r_q.link) begin
                    r_d.lr_we = 1'b1;
                    r_d.lr    = lr_fixed_w;
                end
            end
            ST_FIX: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, pc: '0, lr: '0,
                     link: 1'b0, lr_we: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.state != ST_IDLE);
    assign flush_o   = busy_o;
    assign fetch_o   = busy_o;
    assign addr_o    = r_q.addr;
    assign lr_we_o   = r_q.lr_we;
    assign lr_data_o = r_q.lr;
    assign done_o    = r_q.done;

    // R5
    done_in_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ##2 done_o);

    // R5
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R3
    addr_word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (addr_o == $past(addr_o) + WORD_V));

    // R4
    link_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we_o && $past(lr_we_o)) |-> (lr_data_o == $past(lr_data_o) - WORD_V));

    // R6
    lr_we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |-> (busy_o && !$rose(busy_o)));

    // R8
    idle_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o) && !$rose(busy_o)) |-> $stable(addr_o));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/branch_seq_bench.sv
module branch_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        link_i = 1'b0;
    logic [23:0] offset_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] addr_o;
    logic        fetch_o;
    logic        lr_we_o;
    logic [31:0] lr_data_o;
    logic        busy_o;
    logic        flush_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    branch_seq u_branch_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .link_i   (link_i),
        .offset_i (offset_i),
        .pc_i     (pc_i),
        .addr_o   (addr_o),
        .fetch_o  (fetch_o),
        .lr_we_o  (lr_we_o),
        .lr_data_o(lr_data_o),
        .busy_o   (busy_o),
        .flush_o  (flush_o),
        .done_o   (done_o)
    );

    function automatic logic [31:0] exp_target(logic [31:0] pc, logic [23:0] off);
        int signed soff;
        soff = int'($signed(off));
        return pc + 32'(soff * 4);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_branch(logic lnk, logic [23:0] off, logic [31:0] pc, logic noise);
        logic [31:0] tgt;
        tgt = exp_target(pc, off);
        @(negedge clk);
        start_i = 1'b1; link_i = lnk; offset_i = off; pc_i = pc;
        @(negedge clk);
        chk("R2", "addr", addr_o, tgt);
        chk("R2", "busy/flush/fetch", {29'd0, busy_o, flush_o, fetch_o}, 32'd7);
        chk("R5", "done c1", {31'd0, done_o}, 32'd0);
        chk("R6", "we c1", {31'd0, lr_we_o}, 32'd0);
        // R7: disturb inputs while busy
        start_i = noise; link_i = ~lnk; offset_i = $urandom; pc_i = $urandom;
        @(negedge clk);
        chk("R3", "addr c2", addr_o, tgt + 32'd4);
        chk(lnk ? "R3" : "R6", "we c2", {31'd0, lr_we_o}, {31'd0, lnk});
        if (lnk) chk("R3", "lr c2", lr_data_o, pc);
        chk("R5", "busy c2", {30'd0, busy_o, done_o}, 32'd2);
        start_i = noise; offset_i = $urandom; pc_i = $urandom;
        @(negedge clk);
        chk("R4", "addr c3", addr_o, tgt + 32'd8);
        chk(lnk ? "R4" : "R6", "we c3", {31'd0, lr_we_o}, {31'd0, lnk});
        if (lnk) chk("R4", "lr c3", lr_data_o, pc - 32'd4);
        chk("R5", "busy/done c3", {30'd0, busy_o, done_o}, 32'd3);
        start_i = 1'b0;
        @(negedge clk);
        chk("R5", "busy/done end", {29'd0, busy_o, flush_o, done_o}, 32'd0);
        chk("R8", "idle fetch/we", {30'd0, fetch_o, lr_we_o}, 32'd0);
        chk("R8", "idle addr hold", addr_o, tgt + 32'd8);
        @(negedge clk);
        chk("R7", "still idle", {31'd0, busy_o}, 32'd0);
        chk("R8", "addr hold 2", addr_o, tgt + 32'd8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_b12c;
        void'($urandom(seed));
        #5;
        chk("R1", "reset flags", {27'd0, busy_o, flush_o, fetch_o, lr_we_o, done_o}, 32'd0);
        chk("R1", "reset addr", addr_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset idle", {31'd0, busy_o}, 32'd0);
        chk("R1", "post-reset addr", addr_o, 32'd0);

        run_branch(1'b1, 24'h000000, 32'h0000_1008, 1'b0);
        run_branch(1'b1, 24'h7FFFFF, 32'h1000_0000, 1'b1);
        run_branch(1'b0, 24'h800000, 32'hFFFF_FFF0, 1'b1);
        run_branch(1'b1, 24'hFFFFFF, 32'h0000_0000, 1'b0);
        run_branch(1'b0, 24'h000001, 32'hFFFF_FFFC, 1'b0);
        run_branch(1'b1, 24'hFFFFFE, 32'h0000_0004, 1'b1);
        for (int i = 0; i < 40; i++) begin
            run_branch(1'($urandom), 24'($urandom), {$urandom} & 32'hFFFF_FFFC, 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule